// File: doc/BRIEF.md
# Prioritised Interrupt Index Register

This block collects a vector of interrupt event lines into a sticky raw status register. An enable mask qualifies the raw status, and the result is a masked status that drives a single interrupt request output. A processor services the block through a small register window. The window holds the raw status, the enable mask, the masked status, a priority index, a write-one-to-clear port and a write-one-to-set port.

The index register returns the position of the pending masked interrupt with the highest priority, coded as position plus one, or 0 when nothing is pending. Priority is fixed, and the lowest bit position wins. A processor read of the index retires the interrupt it reports, so the next read presents the next one in order. A read marked as coming from a debugger returns the same value and changes nothing. Software that wants its own ordering can read the masked status and retire bits through the clear port.

Accesses use single-cycle read and write strobes with a register select. Read data is combinational from the current state. Side effects of an access take effect at the clock edge that ends the access.

Top module: `int_index_unit`

## Requirements
- R1: After reset the raw status, the enable mask and the masked status all read 0, the index reads 0 and irqOut is low.
- R2: The masked status (address 2) reads the raw status (address 0) ANDed bit by bit with the enable mask (address 1).
- R3: The index (address 3) reads 0 when no masked status bit is set.
- R4: When masked bits are pending, the index reads the lowest set bit position plus one, so bit 0 reads 1 and bit 31 reads 32.
- R5: A non-debug read of the index clears the reported bit in the raw status, and therefore in the masked status, at the end of the access. The next index read then reports the next pending bit, or 0.
- R6: An index read with dbgAccess high returns the same value and clears nothing.
- R7: Writing to address 4 clears every raw status bit whose write data bit is 1. Other bits are unchanged.
- R8: Writing to address 5 sets every raw status bit whose write data bit is 1, and a high evtIn bit sets its raw status bit at the next clock edge.
- R9: When a bit is set (by evtIn or a write to address 5) in the same cycle as it is cleared (by address 4 or an index read), the bit ends up set.
- R10: irqOut is high exactly when at least one masked status bit is set.
- R11: The enable mask is read and written at address 1. Raw bits that are not enabled stay pending but are neither indexed nor signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_SRC | Event lines; a high bit sets its raw status bit |
| rdEn | input | 1 | Read strobe for the selected register |
| wrEn | input | 1 | Write strobe for the selected register |
| addr | input | 3 | Register select: 0 raw, 1 enable, 2 masked, 3 index, 4 clear, 5 set |
| wrData | input | NUM_SRC | Write data |
| dbgAccess | input | 1 | Marks the current read as a debugger access |
| rdData | output | NUM_SRC | Read data of the selected register (clear and set ports read 0) |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that rdEn and wrEn are never high together. They also assume that an index read is decoded only at address 3, so a retiring read is a single-cycle rdEn pulse with dbgAccess low. The bench drives every access as one strobe held for exactly one clock, and it never raises both strobes at once. Event pulses are applied only in the same window as an access or between accesses, so the rule that a set beats a clear is only exercised where the stimulus makes the collision deliberate.

// File: rtl/int_index_pkg.sv
package int_index_pkg;

  typedef enum logic [2:0] {
    REG_RAW    = 3'd0,
    REG_ENABLE = 3'd1,
    REG_MASKED = 3'd2,
    REG_INDEX  = 3'd3,
    REG_CLEAR  = 3'd4,
    REG_SET    = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic     maskWr;
    logic     clrWr;
    logic     setWr;
    logic     idxPop;
    reg_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/int_index_ctrl.sv
module int_index_ctrl
  import int_index_pkg::*;
(
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic       dbgAccess,
  output strobe_t    strobe
);

  reg_sel_e sel;

  always_comb begin
    sel = reg_sel_e'(addr);
    strobe.maskWr = wrEn && (sel == REG_ENABLE);
    strobe.clrWr  = wrEn && (sel == REG_CLEAR);
    strobe.setWr  = wrEn && (sel == REG_SET);
    // only a processor read retires the reported interrupt
    strobe.idxPop = rdEn && (sel == REG_INDEX) && !dbgAccess;
    strobe.rdSel  = sel;
  end

endmodule

// File: rtl/int_index_dp.sv
module int_index_dp
  import int_index_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  strobe_t            strobe,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] rawStat,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] rawQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] masked;
  logic [NUM_SRC-1:0] lowBit;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] setVec;
  logic [IDX_W-1:0]   idxVal;

  assign masked = rawQ & maskQ;
  // isolate lowest set bit: highest priority
  assign lowBit = masked & (~masked + 1'b1);

  always_comb begin
    idxVal = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (masked[i]) idxVal = IDX_W'(i + 1);
    end
  end

  assign clrVec = (strobe.clrWr  ? wrData : '0) | (strobe.idxPop ? lowBit : '0);
  assign setVec = evtIn | (strobe.setWr ? wrData : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
    end else begin
      rawQ <= (rawQ & ~clrVec) | setVec;
      if (strobe.maskWr) maskQ <= wrData;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      REG_RAW:    rdData = rawQ;
      REG_ENABLE: rdData = maskQ;
      REG_MASKED: rdData = masked;
      REG_INDEX:  rdData = NUM_SRC'(idxVal);
      default:    rdData = '0;
    endcase
  end

  assign rawStat = rawQ;
  assign irqOut  = |masked;

endmodule

// File: rtl/int_index_unit.sv
module int_index_unit
  import int_index_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [2:0]         addr,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               dbgAccess,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);

  strobe_t            strobe;
  logic [NUM_SRC-1:0] rawStat;

  int_index_ctrl u_ctrl (
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .addr      (addr),
    .dbgAccess (dbgAccess),
    .strobe    (strobe)
  );

  int_index_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData),
    .rawStat (rawStat),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/int_index_unit_chk.sv
module int_index_unit_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtIn,
  input logic               rdEn,
  input logic               wrEn,
  input logic [2:0]         addr,
  input logic [NUM_SRC-1:0] wrData,
  input logic               dbgAccess,
  input logic [NUM_SRC-1:0] rdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] rawStat
);

  logic               idxRd;
  logic               cpuPop;
  logic [NUM_SRC-1:0] setNow;
  logic [NUM_SRC-1:0] popBit;
  logic               pendValid;
  logic [NUM_SRC-1:0] pendVec;

  assign idxRd  = rdEn && (addr == 3'd3);
  assign cpuPop = idxRd && !dbgAccess && (rdData != '0);
  assign setNow = evtIn | ((wrEn && addr == 3'd5) ? wrData : '0);
  assign popBit = {{(NUM_SRC-1){1'b0}}, 1'b1} << (rdData - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendVec   <= '0;
    end else begin
      pendValid <= cpuPop;
      pendVec   <= popBit & ~setNow;
    end
  end

  // R3
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxRd && !irqOut) |-> (rdData == '0));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxRd |-> (rdData <= NUM_SRC));

  // R5
  pop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> ((rawStat & pendVec) == '0));

  // R6
  dbg_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxRd && dbgAccess && !wrEn) |=> (rawStat == ($past(rawStat) | $past(evtIn))));

  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((rawStat & $past(evtIn)) == $past(evtIn)));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd2) |-> ((rdData != '0) == irqOut));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> !irqOut);

endmodule

bind int_index_unit int_index_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .dbgAccess (dbgAccess),
  .rdData    (rdData),
  .irqOut    (irqOut),
  .rawStat   (rawStat)
);

// File: tb/int_index_unit_bench.sv
module int_index_unit_bench;

  localparam int N = 32;

  typedef struct packed {
    logic        isWr;
    logic        dbg;
    logic [2:0]  a;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h0,        4'd1},  // R1 raw zero
    '{1'b0, 1'b0, 3'd3, 32'h0,        32'h0,        4'd3},  // R3 empty index
    '{1'b1, 1'b0, 3'd5, 32'h80000014, 32'h0,        4'd8},  // R8 set bits 2,4,31
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h80000014, 4'd8},  // R8
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h0,        4'd2},  // R2 mask zero
    '{1'b0, 1'b0, 3'd3, 32'h0,        32'h0,        4'd11}, // R11 not indexed
    '{1'b1, 1'b0, 3'd1, 32'h80000010, 32'h0,        4'd11}, // R11 enable 4,31
    '{1'b0, 1'b0, 3'd1, 32'h0,        32'h80000010, 4'd11}, // R11 readback
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h80000010, 4'd2},  // R2
    '{1'b0, 1'b1, 3'd3, 32'h0,        32'd5,        4'd6},  // R6 debug read
    '{1'b0, 1'b1, 3'd3, 32'h0,        32'd5,        4'd6},  // R6 unchanged
    '{1'b0, 1'b0, 3'd3, 32'h0,        32'd5,        4'd4},  // R4 pops bit 4
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h80000004, 4'd5},  // R5 bit 4 gone
    '{1'b0, 1'b0, 3'd3, 32'h0,        32'd32,       4'd5},  // R5 next is bit 31
    '{1'b0, 1'b0, 3'd3, 32'h0,        32'd0,        4'd5},  // R5 none left
    '{1'b1, 1'b0, 3'd1, 32'hFFFFFFFF, 32'h0,        4'd11}, // R11 enable all
    '{1'b0, 1'b1, 3'd3, 32'h0,        32'd3,        4'd4},  // R4 bit 2 -> 3
    '{1'b1, 1'b0, 3'd4, 32'h00000004, 32'h0,        4'd7},  // R7 clear bit 2
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h0,        4'd7}   // R7
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] evtIn = '0;
  logic         rdEn = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wrData = '0;
  logic         dbgAccess = 1'b0;
  logic [N-1:0] rdData;
  logic         irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  int_index_unit #(.NUM_SRC(N)) u_int_index_unit (
    .clk (clk), .rstN (rstN), .evtIn (evtIn), .rdEn (rdEn), .wrEn (wrEn),
    .addr (addr), .wrData (wrData), .dbgAccess (dbgAccess),
    .rdData (rdData), .irqOut (irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access window: drive at falling edge, sample before the rising edge
  task automatic access(input logic w, input logic d, input logic [2:0] a,
                        input logic [31:0] data, input logic [31:0] ev,
                        output logic [31:0] got);
    @(negedge clk);
    rdEn = !w; wrEn = w; dbgAccess = d; addr = a; wrData = data; evtIn = ev;
    #1 got = rdData;
    @(posedge clk);
    #1 rdEn = 1'b0; wrEn = 1'b0; dbgAccess = 1'b0; wrData = '0; evtIn = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(posedge clk);
    #1 check("R1 irq after reset", 32'(irqOut), 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].isWr, VECS[v].dbg, VECS[v].a, VECS[v].data, 32'h0, got);
      if (!VECS[v].isWr) check($sformatf("R%0d vector %0d", VECS[v].req, v), got, VECS[v].exp);
    end

    // R8 event lines 0 and 7; R4 bit 0 reports 1; R10 request raised
    access(1'b0, 1'b0, 3'd0, 32'h0, 32'h00000081, got);
    access(1'b0, 1'b1, 3'd3, 32'h0, 32'h0, got);
    check("R8/R4 index after events", got, 32'd1);
    #1 check("R10 irq high", 32'(irqOut), 32'd1);

    // R9 index pop of bit 0 while event 0 fires again: bit stays
    access(1'b0, 1'b0, 3'd3, 32'h0, 32'h00000001, got);
    check("R9 popped index", got, 32'd1);
    access(1'b0, 1'b1, 3'd3, 32'h0, 32'h0, got);
    check("R9 bit 0 still pending", got, 32'd1);

    // R9 clear write of bit 9 with event 9 in same cycle
    access(1'b1, 1'b0, 3'd4, 32'h00000200, 32'h00000200, got);
    access(1'b0, 1'b0, 3'd0, 32'h0, 32'h0, got);
    check("R9 clear vs event", got, 32'h00000281);

    // R7 clear everything; R10 request drops
    access(1'b1, 1'b0, 3'd4, 32'hFFFFFFFF, 32'h0, got);
    access(1'b0, 1'b0, 3'd0, 32'h0, 32'h0, got);
    check("R7 clear all", got, 32'h0);
    #1 check("R10 irq low", 32'(irqOut), 32'd0);

    // R11 disabled source stays pending without request
    access(1'b1, 1'b0, 3'd1, 32'h0, 32'h0, got);
    access(1'b1, 1'b0, 3'd5, 32'h00000008, 32'h0, got);
    #1 check("R11 irq masked off", 32'(irqOut), 32'd0);
    access(1'b0, 1'b0, 3'd0, 32'h0, 32'h0, got);
    check("R11 raw kept", got, 32'h00000008);
    access(1'b1, 1'b0, 3'd1, 32'h00000008, 32'h0, got);
    #1 check("R10 irq on enable", 32'(irqOut), 32'd1);
    access(1'b0, 1'b0, 3'd3, 32'h0, 32'h0, got);
    check("R4 bit 3 index", got, 32'd4);
    access(1'b0, 1'b0, 3'd2, 32'h0, 32'h0, got);
    check("R5 masked after pop", got, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule